// File: doc/BRIEF.md
# Converter Result Readout Controller

This block sits between the digital core of a 16-bit converter and a host. It accepts a start request and a result word from an abstract conversion core, which is modelled as a counter of fixed length. It then hands the result to the host over one of two paths. The serial path makes the block the clock master. It divides the system clock down to a bit clock, shifts the word out most-significant bit first, and raises a frame qualifier while the word is on the line. The parallel path drives a 16-bit three-state bus that a host reads with active-low select and read strobes. A swap control exchanges the two bytes, so an 8-bit host can fetch the word in two reads.

A busy flag covers each conversion. In read-after-convert timing a result is sent right after it is made, and busy stays up until the last bit has gone out. In read-during-convert timing the previous result is sent while the next conversion runs. Busy then covers only the conversion, which allows the highest throughput. The polarity of the bit clock and the polarity of the qualifier can each be inverted.

Top module: `adc_readout_ctrl`

## Requirements
- R1: `ser_sel` high selects the serial path, and the parallel bus is then never driven. `ser_sel` low selects the parallel path.
- R2: A serial word is 16 bits long and is sent MSB first, one bit per `sclk` pulse, with exactly 16 pulses. Each bit lasts SCLK_DIV system clocks (default 4).
- R3: `sync` is active for the whole word, which is 16*SCLK_DIV cycles, and inactive at all other times. While no word is being sent, `sclk` rests at its inactive level.
- R4: `sclk_inv` high makes the inactive level of `sclk` high. `sync_inv` high makes `sync` active low. Both default to the non-inverted state: idle low and active high.
- R5: With `clk_src_ext` high, the block makes no `sclk` pulses and never asserts `sync`.
- R6: With `rd_during` low, serial output of a result begins in the cycle after its conversion ends. `busy` stays high for CONV_CYCLES + 16*SCLK_DIV cycles, counted from the cycle after the accepted start, and falls in the same cycle that `sync` goes inactive.
- R7: With `rd_during` high, `busy` is high for exactly CONV_CYCLES cycles. The result of the previous conversion is sent during the next conversion, starting in the cycle after that start is accepted. The first conversion after reset sends nothing.
- R8: On the parallel bus with `byte_swap` low, `par_d[15:8]` carries the high byte of the result and `par_d[7:0]` the low byte. With `byte_swap` high, the two bytes change places.
- R9: The parallel bus is high-impedance unless `cs_n` and `rd_n` are both low.
- R10: A `conv_start` that arrives while `busy` is high has no effect. This includes the last cycle of `busy`, and it neither lengthens `busy` nor starts a new conversion.
- R11: `sdout` changes only while `sclk` is at its inactive level, so it is steady across every active phase.
- R12: After reset, `busy` is low, `sclk` is at its inactive level and `sync` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Request to start a conversion |
| sample_in | input | 16 | Result word of the conversion core |
| ser_sel | input | 1 | 1 = serial path, 0 = parallel path |
| clk_src_ext | input | 1 | 1 = bit clock is not made internally |
| rd_during | input | 1 | 1 = read during next conversion, 0 = read after own conversion |
| sclk_inv | input | 1 | Invert bit clock polarity |
| sync_inv | input | 1 | Invert qualifier polarity |
| cs_n | input | 1 | Parallel chip select, active low |
| rd_n | input | 1 | Parallel read strobe, active low |
| byte_swap | input | 1 | Exchange bytes on the parallel bus |
| busy | output | 1 | Conversion (and read-after shift) in progress |
| sclk | output | 1 | Serial bit clock |
| sync | output | 1 | Serial word qualifier |
| sdout | output | 1 | Serial data |
| par_d | inout | 16 | Three-state parallel data bus |

## Verification
Two events can fall into one cycle: a new start request and the end of a conversion, when `busy` is about to drop. The bench raises `conv_start` in the last cycle that `busy` is high. It then requires `busy` to fall on time and stay low for the rest of the window, and in read-during timing it requires no second word to appear. A second case raises a request in the middle of a conversion and checks that the width of `busy` is unchanged.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int unsigned LANE_W = 8;

  // Mode captured when a conversion is accepted
  typedef struct packed {
    logic ser_en;   // serial path with internal bit clock
    logic raf;      // read-after-convert timing
  } rd_mode_t;

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_CYCLES = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic done
);
  localparam int unsigned CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  assign running = run_q;
  assign done    = run_q && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start && !run_q) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == CNT_LAST) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/adc_ser_shifter.sv
module adc_ser_shifter #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned SCLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  output logic              active,
  output logic              sclk_act,
  output logic              sd,
  output logic              last
);
  localparam int unsigned PW = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
  localparam int unsigned BW = $clog2(WORD_W);
  localparam logic [PW-1:0] PH_LAST = PW'(SCLK_DIV - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(SCLK_DIV / 2);
  localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

  logic              act_q, act_d;
  logic [PW-1:0]     ph_q, ph_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              ph_end;

  assign ph_end   = (ph_q == PH_LAST);
  assign active   = act_q;
  assign sclk_act = act_q && (ph_q >= PH_HALF);
  assign sd       = act_q & sh_q[WORD_W-1];
  assign last     = act_q && ph_end && (bit_q == BIT_LAST);

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    if (load && !act_q) begin
      act_d = 1'b1;
      ph_d  = '0;
      bit_d = '0;
      sh_d  = load_word;
    end else if (act_q) begin
      if (ph_end) begin
        ph_d  = '0;
        sh_d  = {sh_q[WORD_W-2:0], 1'b0};
        bit_d = bit_q + 1'b1;
        if (bit_q == BIT_LAST) begin
          act_d = 1'b0;
          bit_d = '0;
        end
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/adc_par_port.sv
module adc_par_port #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              par_mode,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              byte_swap,
  input  logic [WORD_W-1:0] word,
  output logic              oe,
  output logic [WORD_W-1:0] drive
);
  import adc_rd_pkg::*;

  localparam int unsigned NLANE = WORD_W / LANE_W;

  logic [WORD_W-1:0] swapped;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign swapped[g*LANE_W +: LANE_W] = word[(NLANE-1-g)*LANE_W +: LANE_W];
  end

  assign oe    = par_mode && !cs_n && !rd_n;
  assign drive = byte_swap ? swapped : word;
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SCLK_DIV    = 4,
  parameter int unsigned CONV_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic [WORD_W-1:0] sample_in,
  input  logic              ser_sel,
  input  logic              clk_src_ext,
  input  logic              rd_during,
  input  logic              sclk_inv,
  input  logic              sync_inv,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              byte_swap,
  output logic              busy,
  output logic              sclk,
  output logic              sync,
  output logic              sdout,
  inout  wire  [WORD_W-1:0] par_d
);
  import adc_rd_pkg::*;

  // reset: asserted asynchronously, released on clk
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic              accept, conv_done, conv_running;
  logic              busy_q, busy_d;
  rd_mode_t          mode_q, mode_d;
  logic [WORD_W-1:0] core_q, core_d;
  logic              have_q, have_d;
  logic              raf_wait_q, raf_wait_d;
  logic              rdc_load, raf_load, sh_load;
  logic [WORD_W-1:0] sh_word;
  logic              sh_active, sh_sclk_act, sh_sd, sh_last;
  logic              par_oe;
  logic [WORD_W-1:0] par_drive;
  logic              raf_mode, ser_mode;

  assign accept   = conv_start && !busy_q;
  assign rdc_load = accept && ser_sel && !clk_src_ext && rd_during
                    && have_q && !sh_active;
  assign raf_load = conv_done && mode_q.ser_en && mode_q.raf;
  assign sh_load  = rdc_load || raf_load;
  assign sh_word  = raf_load ? sample_in : core_q;
  assign raf_mode = mode_q.raf;
  assign ser_mode = mode_q.ser_en;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (accept),
    .running (conv_running),
    .done    (conv_done)
  );

  adc_ser_shifter #(.WORD_W(WORD_W), .SCLK_DIV(SCLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_i),
    .load      (sh_load),
    .load_word (sh_word),
    .active    (sh_active),
    .sclk_act  (sh_sclk_act),
    .sd        (sh_sd),
    .last      (sh_last)
  );

  adc_par_port #(.WORD_W(WORD_W)) u_par (
    .par_mode  (!ser_sel),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .byte_swap (byte_swap),
    .word      (core_q),
    .oe        (par_oe),
    .drive     (par_drive)
  );

  always_comb begin
    busy_d     = busy_q;
    mode_d     = mode_q;
    core_d     = core_q;
    have_d     = have_q;
    raf_wait_d = raf_wait_q;
    if (accept) begin
      busy_d        = 1'b1;
      mode_d.ser_en = ser_sel && !clk_src_ext;
      mode_d.raf    = !rd_during;
    end
    if (conv_done) begin
      core_d = sample_in;
      if (raf_load) raf_wait_d = 1'b1;
      else          busy_d     = 1'b0;
    end
    if (sh_last && raf_wait_q) begin
      busy_d     = 1'b0;
      raf_wait_d = 1'b0;
    end
    if (rdc_load)       have_d = 1'b0;
    else if (conv_done) have_d = !raf_load;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      busy_q     <= 1'b0;
      mode_q     <= '0;
      core_q     <= '0;
      have_q     <= 1'b0;
      raf_wait_q <= 1'b0;
    end else begin
      busy_q     <= busy_d;
      mode_q     <= mode_d;
      core_q     <= core_d;
      have_q     <= have_d;
      raf_wait_q <= raf_wait_d;
    end
  end

  assign busy  = busy_q;
  assign sclk  = sh_sclk_act ^ sclk_inv;
  assign sync  = sh_active ^ sync_inv;
  assign sdout = sh_sd;
  assign par_d = par_oe ? par_drive : {WORD_W{1'bz}};

  logic unused_ok;
  assign unused_ok = conv_running;
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk (
  input logic clk,
  input logic rst_i,
  input logic conv_start,
  input logic busy,
  input logic sclk,
  input logic sclk_inv,
  input logic sdout,
  input logic sh_active,
  input logic raf_mode,
  input logic ser_mode,
  input logic par_oe,
  input logic cs_n,
  input logic rd_n,
  input logic ser_sel
);
  logic sclk_hi;
  assign sclk_hi = sclk ^ sclk_inv;

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_i)
    !sh_active |-> (sclk == sclk_inv));

  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(busy) |-> $past(conv_start) && !$past(busy));

  assert_sdout_steady_R11: assert property (@(posedge clk) disable iff (!rst_i)
    (sclk_hi && $past(sclk_hi)) |-> $stable(sdout));

  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_i)
    ($fell(busy) && raf_mode && ser_mode) |-> $fell(sh_active));

  assert_bus_release_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (cs_n || rd_n || ser_sel) |-> !par_oe);
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .conv_start (conv_start),
  .busy       (busy),
  .sclk       (sclk),
  .sclk_inv   (sclk_inv),
  .sdout      (sdout),
  .sh_active  (sh_active),
  .raf_mode   (raf_mode),
  .ser_mode   (ser_mode),
  .par_oe     (par_oe),
  .cs_n       (cs_n),
  .rd_n       (rd_n),
  .ser_sel    (ser_sel)
);

// File: tb/adc_readout_ctrl_tb.sv
module adc_readout_ctrl_tb;
  localparam int CONV = 80;
  localparam int DIV  = 4;

  logic        clk, rst_n;
  logic        conv_start, ser_sel, clk_src_ext, rd_during;
  logic        sclk_inv, sync_inv, cs_n, rd_n, byte_swap;
  logic [15:0] sample_in;
  logic        busy, sclk, sync, sdout;
  wire  [15:0] par_d;
  logic        tb_en;
  logic [15:0] tb_val;

  assign par_d = tb_en ? tb_val : 16'hzzzz;

  int checks = 0, errors = 0, cyc = 0;
  int busy_cnt, sync_cnt, pulses, first_sync, stab_err;
  logic [15:0] word;

  adc_readout_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .sample_in(sample_in),
    .ser_sel(ser_sel), .clk_src_ext(clk_src_ext), .rd_during(rd_during),
    .sclk_inv(sclk_inv), .sync_inv(sync_inv), .cs_n(cs_n), .rd_n(rd_n),
    .byte_swap(byte_swap), .busy(busy), .sclk(sclk), .sync(sync),
    .sdout(sdout), .par_d(par_d)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start();
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  // samples once per cycle at the falling clock edge; optional late request
  task automatic observe(input int n, input int inject);
    logic prev_act, prev_sd, act, sy;
    busy_cnt = 0; sync_cnt = 0; pulses = 0; first_sync = -1; stab_err = 0;
    word = '0;
    prev_act = sclk ^ sclk_inv;
    prev_sd  = sdout;
    for (int i = 0; i < n; i++) begin
      act = sclk ^ sclk_inv;
      sy  = sync ^ sync_inv;
      if (busy) busy_cnt++;
      if (sy) begin
        sync_cnt++;
        if (first_sync < 0) first_sync = i;
      end
      if (act && !prev_act) begin
        pulses++;
        word = {word[14:0], sdout};
      end
      if (act && prev_act && (sdout != prev_sd)) stab_err++;
      prev_act = act;
      prev_sd  = sdout;
      if (i == inject) conv_start = 1'b1;
      if (i == inject + 1) conv_start = 1'b0;
      @(negedge clk);
    end
    conv_start = 1'b0;
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R12 busy after reset", busy, 0);
    check(sclk == 1'b0, "R12 sclk idle after reset", sclk, 0);
    check(sync == 1'b0, "R12 sync inactive after reset", sync, 0);
  endtask

  task automatic t_parallel();
    ser_sel = 1'b0; rd_during = 1'b1; sample_in = 16'hA5C3;
    pulse_start();
    observe(100, -1);
    check(busy_cnt == CONV, "R7 busy width parallel", busy_cnt, CONV);
    cs_n = 1'b0; rd_n = 1'b0; byte_swap = 1'b0; #1;
    check(par_d == 16'hA5C3, "R8 normal byte order", par_d, 16'hA5C3);
    byte_swap = 1'b1; #1;
    check(par_d == 16'hC3A5, "R8 swapped byte order", par_d, 16'hC3A5);
    rd_n = 1'b1; tb_val = 16'h5A5A; tb_en = 1'b1; #1;
    check(par_d == 16'h5A5A, "R9 bus released rd_n high", par_d, 16'h5A5A);
    rd_n = 1'b0; cs_n = 1'b1; #1;
    check(par_d == 16'h5A5A, "R9 bus released cs_n high", par_d, 16'h5A5A);
    cs_n = 1'b0; ser_sel = 1'b1; #1;
    check(par_d == 16'h5A5A, "R1 bus released in serial mode", par_d, 16'h5A5A);
    tb_en = 1'b0; cs_n = 1'b1; rd_n = 1'b1; byte_swap = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ignore_mid();
    ser_sel = 1'b0; rd_during = 1'b1;
    pulse_start();
    observe(120, 10);
    check(busy_cnt == CONV, "R10 mid-conversion request ignored", busy_cnt, CONV);
  endtask

  task automatic t_read_after();
    ser_sel = 1'b1; rd_during = 1'b0; sample_in = 16'h1234;
    pulse_start();
    observe(200, -1);
    check(busy_cnt == CONV + 16*DIV, "R6 busy extended", busy_cnt, CONV + 16*DIV);
    check(first_sync == CONV, "R6 shift starts after own conversion", first_sync, CONV);
    check(pulses == 16, "R2 pulse count", pulses, 16);
    check(word == 16'h1234, "R2 word MSB first", word, 16'h1234);
    check(sync_cnt == 16*DIV, "R3 sync width", sync_cnt, 16*DIV);
    check(stab_err == 0, "R11 sdout steady in active phase", stab_err, 0);
    check(sclk == 1'b0 && sync == 1'b0, "R3 idle levels after word", {sclk, sync}, 0);
  endtask

  task automatic t_inverted();
    sclk_inv = 1'b1; sync_inv = 1'b1; #1;
    check(sclk == 1'b1, "R4 inverted sclk idle high", sclk, 1);
    check(sync == 1'b1, "R4 inverted sync idle high", sync, 1);
    sample_in = 16'h8001; rd_during = 1'b0;
    pulse_start();
    observe(200, -1);
    check(word == 16'h8001 && pulses == 16, "R4 word with inversion", word, 16'h8001);
    check(sync_cnt == 16*DIV, "R4 inverted sync width", sync_cnt, 16*DIV);
    sclk_inv = 1'b0; sync_inv = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_read_during();
    apply_reset();
    ser_sel = 1'b1; rd_during = 1'b1; sample_in = 16'hBEEF;
    pulse_start();
    observe(100, -1);
    check(busy_cnt == CONV, "R7 busy width read-during", busy_cnt, CONV);
    check(pulses == 0 && sync_cnt == 0, "R7 first conversion sends nothing", pulses, 0);
    sample_in = 16'h0F0F;
    pulse_start();
    observe(100, -1);
    check(first_sync == 0, "R7 previous word starts with next conversion", first_sync, 0);
    check(word == 16'hBEEF, "R7 previous word sent", word, 16'hBEEF);
    check(busy_cnt == CONV, "R7 busy not extended", busy_cnt, CONV);
    check(stab_err == 0, "R11 sdout steady read-during", stab_err, 0);
    pulse_start();
    observe(100, 79);
    check(word == 16'h0F0F, "R7 second word sent", word, 16'h0F0F);
    check(busy_cnt == CONV, "R10 request in last busy cycle ignored", busy_cnt, CONV);
    observe(100, -1);
    check(busy_cnt == 0 && pulses == 0, "R10 no conversion from late request", busy_cnt, 0);
  endtask

  task automatic t_ext_clock();
    ser_sel = 1'b1; clk_src_ext = 1'b1; rd_during = 1'b0; sample_in = 16'h7777;
    pulse_start();
    observe(200, -1);
    check(pulses == 0 && sync_cnt == 0, "R5 no clock when external", pulses, 0);
    check(busy_cnt == CONV, "R5 busy width external", busy_cnt, CONV);
    clk_src_ext = 1'b0;
  endtask

  initial begin
    conv_start = 0; ser_sel = 1; clk_src_ext = 0; rd_during = 0;
    sclk_inv = 0; sync_inv = 0; cs_n = 1; rd_n = 1; byte_swap = 0;
    sample_in = '0; tb_en = 0; tb_val = '0;
    @(negedge clk);
    apply_reset();
    t_reset();
    t_parallel();
    t_ignore_mid();
    t_read_after();
    t_inverted();
    t_read_during();
    t_ext_clock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule